// File: doc/BRIEF.md
# Serial ADC Conversion Sequencer

This block runs a single conversion on an eight-input serial analog-to-digital converter over SPI. The host raises a request together with a 4-bit logical channel index. The block turns the index into a 3-bit input-select address and a single-ended/differential flag, and forms a one-byte command. It sends that byte with chip select low, releases chip select for a fixed settling gap, and then lowers chip select again to clock in three bytes. Out of those 24 bits it extracts a 16-bit sample and signals completion with a one-cycle strobe.

Indices 0 to 7 select single-ended inputs through an interleaved address order. Indices 8 to 15 select the four adjacent input pairs as differential measurements: first in normal polarity, then in reversed polarity. The gap length comes from the system clock frequency and a nanosecond parameter, rounded up to whole clocks. The SCLK rate is set by a separate half-period divider.

Top module: `adc_seq_ctrl`

## Requirements
- R1: The command byte is {1, addr[2:0], 0, se, 1, 0} from bit 7 down to bit 0. Bit 7 is always 1, bits 6:4 hold the select address, bit 2 (se) is 1 for single-ended and 0 for differential, and bits 1:0 are 2'b10.
- R2: Indices 0,1,2,3,4,5,6,7 are single-ended (se=1) with select addresses 0,4,1,5,2,6,3,7 respectively.
- R3: Indices 8 to 11 are differential (se=0) with addresses 0 to 3. Indices 12 to 15 are differential with addresses 4 to 7.
- R4: A conversion makes exactly two chip-select-low windows: 8 SCLK pulses carrying the command, then 24 SCLK pulses for the read. The data is MSB first in SPI mode 0, with SCLK idle low, MOSI changing after falling edges and MISO sampled on rising edges. SCLK never toggles while chip select is high.
- R5: Between the two windows chip select stays high for at least ceil(GAP_NS·CLK_HZ/1e9) system clocks and at most two clocks more.
- R6: With the 24 read bits numbered 23 (first received) down to 0, the sample equals bits 22:7. All other bits are discarded.
- R7: busy rises the cycle after a request is accepted and falls in the same cycle that done pulses. done is high for exactly one clock.
- R8: The sample output changes only in the cycle done pulses and holds its value until the next conversion completes.
- R9: A request raised while busy is ignored. The running conversion keeps its command, and no extra transfer follows.
- R10: After reset cs_n is 1, sclk is 0, busy and done are 0 and the sample is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Conversion request, sampled while idle |
| chan_idx | input | 4 | Logical channel index 0 to 15 |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle completion strobe |
| sample | output | 16 | Last assembled conversion result |
| sclk | output | 1 | SPI serial clock |
| mosi | output | 1 | SPI data to converter |
| miso | input | 1 | SPI data from converter |
| cs_n | output | 1 | Active-low chip select |

## Verification
A wrong channel decode or a corrupted command register shows up on MOSI during the first chip-select window, within eight SCLK periods of the request. A sequencer state error appears as a missing or extra chip-select window, or as a gap length that differs from the rounded-up clock count, and it is visible before the read begins. A wrong extraction window, or a shift register with the wrong bit order, gives a sample value that differs from bits 22:7 of the driven MISO pattern in the very cycle done pulses. Choosing patterns that have ones only in the discarded bits makes any leak of those bits stand out.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

   localparam int CMD_BITS    = 8;
   localparam int READ_BYTES  = 3;
   localparam int READ_BITS   = READ_BYTES * 8;
   localparam int SAMPLE_W    = 16;
   localparam int SAMPLE_MSB  = READ_BITS - 2;   // first received bit is dropped
   localparam int SEL_W       = 3;
   localparam int IDX_W       = SEL_W + 1;
   localparam logic [1:0] CLK_MODE_INT = 2'b10;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_CMD  = 2'd1,
      ST_GAP  = 2'd2,
      ST_READ = 2'd3
   } seq_state_e;

   typedef struct packed {
      logic             start;
      logic [SEL_W-1:0] sel;
      logic             rsvd;
      logic             single;
      logic [1:0]       mode;
   } cmd_byte_t;

endpackage

// File: rtl/adc_cmd_map.sv
module adc_cmd_map
   import adc_seq_pkg::*;
(
   input  logic [IDX_W-1:0]    idx,
   output logic [CMD_BITS-1:0] cmd
);

   cmd_byte_t        c;
   logic [SEL_W-1:0] sel;
   logic             diff;

   always_comb begin
      diff = idx[IDX_W-1];
      if (diff) begin
         // pairs in normal polarity then reversed: address equals low bits
         sel = idx[SEL_W-1:0];
      end else begin
         // interleaved single-ended order: low index bit becomes address MSB
         sel = {idx[0], idx[SEL_W-1:1]};
      end
      c.start  = 1'b1;
      c.sel    = sel;
      c.rsvd   = 1'b0;
      c.single = ~diff;
      c.mode   = CLK_MODE_INT;
      cmd      = c;
   end

endmodule

// File: rtl/adc_gap_timer.sv
module adc_gap_timer #(
   parameter int CYCLES = 2250
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic expire
);

   localparam int CNT_W = $clog2(CYCLES + 1);

   generate
      if (CYCLES < 1) begin : g_bad_cycles
         $error("adc_gap_timer: CYCLES must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic             run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         run_q  <= 1'b0;
         expire <= 1'b0;
      end else begin
         expire <= 1'b0;
         if (start) begin
            cnt_q <= CNT_W'(CYCLES);
            run_q <= 1'b1;
         end else if (run_q) begin
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CNT_W'(1)) begin
               run_q  <= 1'b0;
               expire <= 1'b1;
            end
         end
      end
   end

   a_r5_expire_single : assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> !expire);

endmodule

// File: rtl/adc_spi_shifter.sv
module adc_spi_shifter #(
   parameter int HALF_DIV = 4,
   parameter int MAX_BITS = 24,
   localparam int CW      = $clog2(MAX_BITS + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [CW-1:0]       nbits,
   input  logic [MAX_BITS-1:0] tx_word,
   input  logic                miso,
   output logic                sclk,
   output logic                mosi,
   output logic [MAX_BITS-1:0] rx_word,
   output logic                active,
   output logic                fin
);

   generate
      if (HALF_DIV < 1) begin : g_bad_div
         $error("adc_spi_shifter: HALF_DIV must be at least 1");
      end
      if (MAX_BITS < 2) begin : g_bad_bits
         $error("adc_spi_shifter: MAX_BITS must be at least 2");
      end
   endgenerate

   logic [MAX_BITS-1:0] tx_sr;
   logic [MAX_BITS-1:0] rx_sr;
   logic [CW-1:0]       bit_q;
   logic [CW-1:0]       nbits_q;
   logic                sclk_q;
   logic                tick;

   generate
      if (HALF_DIV == 1) begin : g_nodiv
         assign tick = active;
      end else begin : g_div
         localparam int DW = $clog2(HALF_DIV);
         logic [DW-1:0] div_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               div_q <= '0;
            end else if (start || !active) begin
               div_q <= '0;
            end else if (div_q == DW'(HALF_DIV - 1)) begin
               div_q <= '0;
            end else begin
               div_q <= div_q + 1'b1;
            end
         end
         assign tick = active && (div_q == DW'(HALF_DIV - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_sr   <= '0;
         rx_sr   <= '0;
         bit_q   <= '0;
         nbits_q <= '0;
         sclk_q  <= 1'b0;
         active  <= 1'b0;
         fin     <= 1'b0;
      end else begin
         fin <= 1'b0;
         if (start) begin
            tx_sr   <= tx_word;
            bit_q   <= '0;
            nbits_q <= nbits;
            sclk_q  <= 1'b0;
            active  <= 1'b1;
         end else if (tick) begin
            if (!sclk_q) begin
               sclk_q <= 1'b1;
               rx_sr  <= {rx_sr[MAX_BITS-2:0], miso};
            end else begin
               sclk_q <= 1'b0;
               tx_sr  <= {tx_sr[MAX_BITS-2:0], 1'b0};
               bit_q  <= bit_q + 1'b1;
               if (bit_q + 1'b1 == nbits_q) begin
                  active <= 1'b0;
                  fin    <= 1'b1;
               end
            end
         end
      end
   end

   assign sclk    = sclk_q;
   assign mosi    = tx_sr[MAX_BITS-1];
   assign rx_word = rx_sr;

   a_r4_bit_bound : assert property (@(posedge clk) disable iff (!rst_n)
      active |-> (bit_q < nbits_q));
   a_r4_idle_low : assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> !sclk_q);

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
   import adc_seq_pkg::*;
#(
   parameter int CLK_HZ   = 250_000_000,
   parameter int GAP_NS   = 9000,
   parameter int HALF_DIV = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req,
   input  logic [IDX_W-1:0]    chan_idx,
   output logic                busy,
   output logic                done,
   output logic [SAMPLE_W-1:0] sample,
   output logic                sclk,
   output logic                mosi,
   input  logic                miso,
   output logic                cs_n
);

   localparam longint GAP_PROD = longint'(CLK_HZ) * longint'(GAP_NS);
   localparam int     GAP_CYC  = int'((GAP_PROD + 64'd999_999_999) / 64'd1_000_000_000);
   localparam int     CW       = $clog2(READ_BITS + 1);
   localparam int     GW       = $clog2(GAP_CYC + 2);

   generate
      if (CLK_HZ < 1 || GAP_NS < 1) begin : g_bad_timing
         $error("adc_seq_ctrl: CLK_HZ and GAP_NS must be positive");
      end
      if (SAMPLE_MSB - SAMPLE_W + 1 < 0) begin : g_bad_window
         $error("adc_seq_ctrl: sample window exceeds read length");
      end
   endgenerate

   seq_state_e           state_q;
   logic [CMD_BITS-1:0]  cmd_w;
   logic [CMD_BITS-1:0]  cmd_q;
   logic                 sh_start;
   logic                 gap_start;
   logic                 gap_exp;
   logic                 sh_fin;
   logic                 sh_active;
   logic [READ_BITS-1:0] rx_w;
   logic [READ_BITS-1:0] tx_w;
   logic [CW-1:0]        nbits_w;
   logic                 sclk_w;

   adc_cmd_map u_map (
      .idx (chan_idx),
      .cmd (cmd_w)
   );

   always_comb begin
      if (state_q == ST_READ) begin
         tx_w    = '0;
         nbits_w = CW'(READ_BITS);
      end else begin
         tx_w    = {cmd_q, {(READ_BITS-CMD_BITS){1'b0}}};
         nbits_w = CW'(CMD_BITS);
      end
   end

   adc_spi_shifter #(
      .HALF_DIV (HALF_DIV),
      .MAX_BITS (READ_BITS)
   ) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (sh_start),
      .nbits   (nbits_w),
      .tx_word (tx_w),
      .miso    (miso),
      .sclk    (sclk_w),
      .mosi    (mosi),
      .rx_word (rx_w),
      .active  (sh_active),
      .fin     (sh_fin)
   );

   adc_gap_timer #(
      .CYCLES (GAP_CYC)
   ) u_gap (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (gap_start),
      .expire (gap_exp)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         cmd_q     <= '0;
         sh_start  <= 1'b0;
         gap_start <= 1'b0;
         done      <= 1'b0;
         sample    <= '0;
      end else begin
         sh_start  <= 1'b0;
         gap_start <= 1'b0;
         done      <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (req) begin
                  cmd_q    <= cmd_w;
                  sh_start <= 1'b1;
                  state_q  <= ST_CMD;
               end
            end
            ST_CMD: begin
               if (sh_fin) begin
                  gap_start <= 1'b1;
                  state_q   <= ST_GAP;
               end
            end
            ST_GAP: begin
               if (gap_exp) begin
                  sh_start <= 1'b1;
                  state_q  <= ST_READ;
               end
            end
            ST_READ: begin
               if (sh_fin) begin
                  sample  <= rx_w[SAMPLE_MSB -: SAMPLE_W];
                  done    <= 1'b1;
                  state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy = (state_q != ST_IDLE);
   assign cs_n = !((state_q == ST_CMD) || (state_q == ST_READ));
   assign sclk = sclk_w;

   wire unused_rx = ^{rx_w[READ_BITS-1], rx_w[SAMPLE_MSB-SAMPLE_W:0], sh_active};

   // gap length observer
   logic [GW-1:0] gap_seen;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap_seen <= '0;
      end else if (state_q == ST_GAP) begin
         if (gap_seen != {GW{1'b1}}) gap_seen <= gap_seen + 1'b1;
      end else begin
         gap_seen <= '0;
      end
   end

   a_r5_gap_min : assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_READ && $past(state_q) == ST_GAP) |-> (gap_seen >= GW'(GAP_CYC)));
   a_r4_no_sclk_cs_high : assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !sclk);
   a_r7_done_pulse : assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r7_done_not_busy : assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   a_r8_sample_hold : assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sample) |-> done);
   a_r9_busy_ignore : assert property (@(posedge clk) disable iff (!rst_n)
      (busy && req) |=> $stable(cmd_q));
   a_r1_start_bit : assert property (@(posedge clk) disable iff (!rst_n)
      sh_start && (state_q == ST_CMD) |-> cmd_q[CMD_BITS-1]);

endmodule

// File: tb/tb_adc_seq_ctrl.sv
`timescale 1ns/1ps
module tb_adc_seq_ctrl;

   localparam int EXP_GAP = 2250;   // 9000 ns at 4 ns per clock

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 1'b0;
   logic [3:0]  chan_idx = 4'd0;
   logic        busy, done, sclk, mosi, cs_n;
   logic        miso = 1'b0;
   logic [15:0] sample;

   always #2 clk = ~clk;

   adc_seq_ctrl dut (
      .clk (clk), .rst_n (rst_n), .req (req), .chan_idx (chan_idx),
      .busy (busy), .done (done), .sample (sample),
      .sclk (sclk), .mosi (mosi), .miso (miso), .cs_n (cs_n)
   );

   int checks = 0;
   int errors = 0;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // SPI slave model, one process for both edges
   logic [23:0] pat = 24'h0;
   logic [23:0] sh = 24'h0;
   logic [7:0]  cur_cap = 8'h0, cmd_cap = 8'h0;
   int cur_bits = 0, cmd_bits = 0, rd_bits = 0, sess = 0;
   logic cs_prev = 1'b1, sclk_prev = 1'b0;

   always @(cs_n, sclk) begin
      if (cs_n !== cs_prev) begin
         if (cs_n === 1'b0) begin
            sess++;
            cur_bits = 0;
            sh = pat;
            miso = pat[23];
         end else if (cs_n === 1'b1 && cs_prev === 1'b0) begin
            if (sess % 2 == 1) begin
               cmd_cap  = cur_cap;
               cmd_bits = cur_bits;
            end else begin
               rd_bits = cur_bits;
            end
         end
      end
      if (sclk !== sclk_prev) begin
         if (sclk === 1'b1) begin
            cur_cap = {cur_cap[6:0], mosi};
            cur_bits++;
         end else if (sclk === 1'b0 && sclk_prev === 1'b1) begin
            sh = {sh[22:0], 1'b0};
            miso = sh[23];
         end
      end
      cs_prev = cs_n;
      sclk_prev = sclk;
   end

   int gap_cnt = 0;
   int done_cnt = 0;
   always @(negedge clk) begin
      if (busy && cs_n) gap_cnt++;
      if (done) done_cnt++;
   end

   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 190000) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   function automatic logic [7:0] exp_cmd(input logic [3:0] idx);
      logic [2:0] se_addr [8] = '{3'd0, 3'd4, 3'd1, 3'd5, 3'd2, 3'd6, 3'd3, 3'd7};
      logic [2:0] a;
      logic       se;
      if (idx < 8) begin a = se_addr[idx[2:0]]; se = 1'b1; end
      else         begin a = 3'(idx - 4'd8);   se = 1'b0; end
      return {1'b1, a, 1'b0, se, 2'b10};
   endfunction

   task automatic issue(input logic [3:0] idx);
      @(negedge clk);
      while (busy) @(negedge clk);
      gap_cnt = 0;
      chan_idx = idx;
      req = 1'b1;
      @(negedge clk);
      chk(busy === 1'b1, "R7 busy after accept", busy, 1);
      req = 1'b0;
   endtask

   task automatic wait_done();
      int n = 0;
      while (done !== 1'b1 && n < 20000) begin @(negedge clk); n++; end
   endtask

   task automatic t_reset();
      chk(cs_n === 1'b1, "R10 cs_n", cs_n, 1);
      chk(sclk === 1'b0, "R10 sclk", sclk, 0);
      chk(busy === 1'b0 && done === 1'b0, "R10 busy/done", {busy, done}, 0);
      chk(sample === 16'h0, "R10 sample", sample, 0);
   endtask

   task automatic t_convert(input logic [3:0] idx, input logic [23:0] p);
      int s0;
      pat = p;
      s0 = sess;
      issue(idx);
      wait_done();
      chk(done === 1'b1 && busy === 1'b0, "R7 done with busy low", {done, busy}, 2);
      chk(sample === p[22:7], "R6 sample", sample, p[22:7]);
      @(negedge clk);
      chk(done === 1'b0, "R7 done one cycle", done, 0);
      if (idx < 8) chk(cmd_cap === exp_cmd(idx), "R2 single-ended command", cmd_cap, exp_cmd(idx));
      else         chk(cmd_cap === exp_cmd(idx), "R3 differential command", cmd_cap, exp_cmd(idx));
      chk(cmd_cap[7] === 1'b1 && cmd_cap[1:0] === 2'b10 && cmd_cap[3] === 1'b0,
          "R1 fixed fields", cmd_cap, exp_cmd(idx));
      chk(cmd_bits == 8 && rd_bits == 24, "R4 bit counts", {cmd_bits, rd_bits}, {32'd8, 32'd24});
      chk(sess - s0 == 2, "R4 two windows", sess - s0, 2);
      chk(gap_cnt >= EXP_GAP && gap_cnt <= EXP_GAP + 2, "R5 gap length", gap_cnt, EXP_GAP);
   endtask

   task automatic t_busy_ignore();
      logic [15:0] prev;
      int s0, d0;
      prev = sample;
      pat = 24'h3C_A5_00;
      s0 = sess;
      d0 = done_cnt;
      issue(4'd3);
      repeat (300) @(negedge clk);
      chk(sample === prev, "R8 sample held during next conversion", sample, prev);
      chan_idx = 4'd12;
      req = 1'b1;
      @(negedge clk);
      req = 1'b0;
      wait_done();
      @(negedge clk);
      chk(cmd_cap === exp_cmd(4'd3), "R9 command unchanged", cmd_cap, exp_cmd(4'd3));
      repeat (200) @(negedge clk);
      chk(sess - s0 == 2, "R9 no extra transfer", sess - s0, 2);
      chk(done_cnt - d0 == 1, "R9 single completion", done_cnt - d0, 1);
      chk(busy === 1'b0, "R9 idle after", busy, 0);
      chk(sample === pat[22:7], "R8 sample held after done", sample, pat[22:7]);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      for (int i = 0; i < 16; i++) begin
         t_convert(4'(i), {8'h5A ^ 8'(i * 17), 8'hC3 + 8'(i), 8'(i) << 4});
      end
      t_convert(4'd0, 24'hFF_FF_FF);
      t_convert(4'd8, 24'h80_00_7F);    // only discarded bits set
      t_convert(4'd15, 24'h7F_FF_80);   // only kept bits set
      t_convert(4'd6, 24'h00_00_00);
      t_busy_ignore();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule